// File: doc/BRIEF.md
# 1-Wire Bus Master Engine

This block is the master side of a single-wire, open-drain serial bus. A host issues one command at a time: a bus reset that listens for a presence response, a single-bit write, a single-bit read, a whole-byte write or a whole-byte read. The engine builds each slot from a ten-entry table of phase durations. The block holds two such tables, one for standard speed and one for overdrive. It drives the shared line low only through `line_drive`, and it watches the line through `line_in`.

A prescaler derives a one-microsecond tick from the system clock, and every phase counter advances on that tick. The prescaler restarts at every phase boundary, so each phase of N microseconds lasts exactly N ticks. A phase of length zero lasts a single clock cycle. The speed select is captured when a command is accepted and holds until that command completes.

Top module: `owire_master`

## Requirements
- R1: After reset, `busy`, `done`, `line_drive`, `presence` and `rd_data` are all zero, and standard speed is in effect.
- R2: Op code 0 (bus reset) runs a fixed sequence: a released wait of 0 µs (standard) or 2 µs (overdrive), then the line held low for 480 µs or 70 µs, then a release. The line is sampled 70 µs or 8 µs after the release, then a tail of 410 µs or 40 µs follows. `presence` becomes 1 when that sample read low, and 0 when it read high.
- R3: Op code 1 writes `cmd_wdata[0]`. A 1 holds the line low for 6 µs (overdrive 1 µs) and a 0 holds it low for 60 µs (overdrive 7 µs). Busy lasts at least the low time plus the recovery time: 64/10 µs standard, 7/2 µs overdrive.
- R4: Op code 2 reads one bit. The line is held low for 6 µs (overdrive 1 µs), then sampled 9 µs (overdrive 1 µs) after the release. The sample lands in `rd_data[0]` with `rd_data[7:1]` cleared.
- R5: Op code 3 writes `cmd_wdata` as eight write slots, least significant bit first.
- R6: Op code 4 reads eight bits into `rd_data`. The first bit received ends in bit 0 and the last in bit 7.
- R7: A nonzero `speed_od` at command acceptance selects the overdrive table and zero selects standard. A change of `speed_od` while busy does not affect the running command.
- R8: A command is accepted only when `cmd_valid` is high, `busy` is low and `cmd_op` is 0 to 4. Commands arriving while busy, and op codes 5 to 7, are ignored and drive no slot.
- R9: `done` is high for exactly one cycle at the end of each command, and `busy` is low in that cycle.
- R10: `rd_data` changes only when a read command completes, and `presence` changes only when a bus reset completes. Both outputs hold between those events.
- R11: `line_drive` is asserted only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 3 | Operation code: 0 reset, 1 write bit, 2 read bit, 3 write byte, 4 read byte |
| cmd_wdata | input | DATA_W | Data to write; bit 0 is used by the single-bit write |
| speed_od | input | 1 | 1 selects overdrive timing, 0 selects standard timing |
| line_in | input | 1 | Level of the shared bus line |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Result of the last read command |
| presence | output | 1 | Presence result of the last bus reset |
| line_drive | output | 1 | 1 pulls the bus line low; 0 releases it |

## Verification
The bench models a responding device on the bus and checks low-pulse widths to the exact cycle. A prescaler that free-runs across phases, or a wrong table entry, shows up as a width off by a few cycles. Standard-speed reset has a zero-length first phase; a design that mishandles it would hang or insert a stray tick of delay. The speed select is toggled in the middle of a slot; a design that failed to latch it would shorten the pulse to the overdrive width. A second command is issued while busy, and illegal op codes are issued; a design that accepted either would produce extra low pulses. Byte reads use asymmetric patterns, so reversed bit order, or a presence flag that was not inverted, gives a visibly wrong value.

// File: rtl/owire_pkg.sv
// Shared types and timing tables for the single-wire bus master.
// Assumes phase durations fit in PH_W bits of microseconds.
package owire_pkg;

    localparam int PH_W = 10;

    typedef enum logic [2:0] {
        OP_RESET = 3'd0,
        OP_WBIT  = 3'd1,
        OP_RBIT  = 3'd2,
        OP_WBYTE = 3'd3,
        OP_RBYTE = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        SK_RESET,
        SK_WRITE,
        SK_READ
    } slot_kind_e;

    // Ten phase durations, grouped by the slot that uses them
    typedef struct packed {
        logic [PH_W-1:0] rst_pre;
        logic [PH_W-1:0] rst_low;
        logic [PH_W-1:0] rst_wait;
        logic [PH_W-1:0] rst_tail;
        logic [PH_W-1:0] one_low;
        logic [PH_W-1:0] one_rel;
        logic [PH_W-1:0] zero_low;
        logic [PH_W-1:0] zero_rel;
        logic [PH_W-1:0] rd_wait;
        logic [PH_W-1:0] rd_tail;
    } phase_tbl_t;

    // Per-slot plan: four phase lengths plus a sample enable
    typedef struct packed {
        logic [PH_W-1:0] pre;
        logic [PH_W-1:0] low;
        logic [PH_W-1:0] rec;
        logic [PH_W-1:0] tail;
        logic            smp;
    } slot_plan_t;

    // Select the whole timing table for a speed mode
    function automatic phase_tbl_t timing_for(input logic od);
        phase_tbl_t t;
        if (od) begin
            t.rst_pre  = PH_W'(2);   t.rst_low  = PH_W'(70);
            t.rst_wait = PH_W'(8);   t.rst_tail = PH_W'(40);
            t.one_low  = PH_W'(1);   t.one_rel  = PH_W'(7);
            t.zero_low = PH_W'(7);   t.zero_rel = PH_W'(2);
            t.rd_wait  = PH_W'(1);   t.rd_tail  = PH_W'(7);
        end else begin
            t.rst_pre  = PH_W'(0);   t.rst_low  = PH_W'(480);
            t.rst_wait = PH_W'(70);  t.rst_tail = PH_W'(410);
            t.one_low  = PH_W'(6);   t.one_rel  = PH_W'(64);
            t.zero_low = PH_W'(60);  t.zero_rel = PH_W'(10);
            t.rd_wait  = PH_W'(9);   t.rd_tail  = PH_W'(55);
        end
        return t;
    endfunction

    // Map a slot kind onto its four phases
    function automatic slot_plan_t plan_slot(input slot_kind_e kind,
                                             input logic wbit,
                                             input phase_tbl_t t);
        slot_plan_t p;
        case (kind)
            SK_RESET: begin
                p.pre = t.rst_pre;  p.low = t.rst_low;
                p.rec = t.rst_wait; p.tail = t.rst_tail; p.smp = 1'b1;
            end
            SK_READ: begin
                p.pre = '0;         p.low = t.one_low;
                p.rec = t.rd_wait;  p.tail = t.rd_tail;  p.smp = 1'b1;
            end
            default: begin
                p.pre  = '0;
                p.low  = wbit ? t.one_low : t.zero_low;
                p.rec  = wbit ? t.one_rel : t.zero_rel;
                p.tail = '0;
                p.smp  = 1'b0;
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/owire_tick.sv
// Restartable microsecond prescaler.
// Assumes CLK_HZ is a whole multiple of 1 MHz and at least 1 MHz.
// tick is high in the last cycle of every microsecond; clr restarts the count.
module owire_tick #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int DIV = CLK_HZ / 1_000_000;
    localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            logic [CW-1:0] cnt;
            // Count clock cycles within the current microsecond
            always_ff @(posedge clk) begin
                if (!rst_n || clr)                cnt <= '0;
                else if (cnt == CW'(DIV - 1))     cnt <= '0;
                else                              cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/owire_sync.sv
// Multi-flop synchroniser for the asynchronous bus line.
// Resets to 1 because an idle, released line reads high.
module owire_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the line level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/owire_slot.sv
// Slot sequencer: runs one reset, write or read slot as four phases
// (released pre-wait, low, released recovery with optional sample, released tail).
// Assumes start arrives only while the sequencer is idle; start while active is ignored.
// Requests a prescaler restart at every phase boundary, so phase timing is exact.
module owire_slot
    import owire_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  slot_kind_e kind,
    input  logic       wbit,
    input  phase_tbl_t tbl,
    input  logic       line_s,
    output logic       tick_clr,
    output logic       drive_low,
    output logic       slot_done,
    output logic       bit_out
);
    typedef enum logic [2:0] {S_IDLE, S_PRE, S_LOW, S_REC, S_TAIL} sstate_e;

    sstate_e         state;
    slot_plan_t      plan_q;
    logic [PH_W-1:0] cnt;
    logic [PH_W-1:0] cur_len;
    logic            phase_end;
    logic            go;

    assign go = start && (state == S_IDLE);

    // Pick the length of the phase now running
    always_comb begin
        case (state)
            S_PRE:   cur_len = plan_q.pre;
            S_LOW:   cur_len = plan_q.low;
            S_REC:   cur_len = plan_q.rec;
            S_TAIL:  cur_len = plan_q.tail;
            default: cur_len = '0;
        endcase
    end

    assign phase_end = (state != S_IDLE) &&
                       ((cur_len == '0) || (tick && (cnt == cur_len - PH_W'(1))));
    assign tick_clr  = go || phase_end;

    // Count elapsed microseconds inside the current phase
    always_ff @(posedge clk) begin
        if (!rst_n || tick_clr) cnt <= '0;
        else if (tick)          cnt <= cnt + 1'b1;
    end

    // Step through the phases, capture the sample and flag the slot end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            plan_q    <= '0;
            slot_done <= 1'b0;
            bit_out   <= 1'b0;
        end else begin
            slot_done <= 1'b0;
            if (go) begin
                plan_q <= plan_slot(kind, wbit, tbl);
                state  <= S_PRE;
            end else if (phase_end) begin
                case (state)
                    S_PRE:  state <= S_LOW;
                    S_LOW:  state <= S_REC;
                    S_REC: begin
                        if (plan_q.smp) bit_out <= line_s;
                        state <= S_TAIL;
                    end
                    default: begin
                        state     <= S_IDLE;
                        slot_done <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign drive_low = (state == S_LOW);
endmodule

// File: rtl/owire_master.sv
// Single-wire bus master top: command intake, speed latch, byte serialisation.
// Assumes line_in is the wired-AND bus level; line_drive=1 pulls the line low.
// One command at a time; the speed mode is latched at command acceptance.
module owire_master
    import owire_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int DATA_W  = 8,
    parameter int SYNC_FF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              speed_od,
    input  logic              line_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              presence,
    output logic              line_drive
);
    localparam int BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef enum logic {T_IDLE, T_RUN} tstate_e;

    tstate_e           state;
    op_e               op_q;
    logic              od_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] rx_next;
    logic [BC_W-1:0]   bit_cnt;
    logic              go_q;
    logic              last_bit;
    logic              accept;
    logic              tick;
    logic              tick_clr;
    logic              line_s;
    logic              slot_done;
    logic              slot_bit;
    slot_kind_e        kind;

    assign accept   = cmd_valid && (state == T_IDLE) && (cmd_op <= 3'(OP_RBYTE));
    assign last_bit = (bit_cnt == BC_W'(DATA_W - 1));
    assign rx_next  = {slot_bit, rx_q[DATA_W-1:1]};

    // Translate the latched command into a slot kind
    always_comb begin
        case (op_q)
            OP_RESET:          kind = SK_RESET;
            OP_RBIT, OP_RBYTE: kind = SK_READ;
            default:           kind = SK_WRITE;
        endcase
    end

    owire_tick #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    owire_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_s)
    );

    owire_slot u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start     (go_q),
        .kind      (kind),
        .wbit      (tx_q[0]),
        .tbl       (timing_for(od_q)),
        .line_s    (line_s),
        .tick_clr  (tick_clr),
        .drive_low (line_drive),
        .slot_done (slot_done),
        .bit_out   (slot_bit)
    );

    // Accept commands, chain slots for byte operations and publish results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= T_IDLE;
            op_q     <= OP_RESET;
            od_q     <= 1'b0;
            tx_q     <= '0;
            rx_q     <= '0;
            bit_cnt  <= '0;
            go_q     <= 1'b0;
            done     <= 1'b0;
            rd_data  <= '0;
            presence <= 1'b0;
        end else begin
            go_q <= 1'b0;
            done <= 1'b0;
            if (accept) begin
                state   <= T_RUN;
                op_q    <= op_e'(cmd_op);
                od_q    <= speed_od;
                tx_q    <= cmd_wdata;
                rx_q    <= '0;
                bit_cnt <= '0;
                go_q    <= 1'b1;
            end else if (state == T_RUN && slot_done) begin
                case (op_q)
                    OP_RESET: begin
                        presence <= ~slot_bit;
                        state    <= T_IDLE;
                        done     <= 1'b1;
                    end
                    OP_RBIT: begin
                        rd_data <= DATA_W'(slot_bit);
                        state   <= T_IDLE;
                        done    <= 1'b1;
                    end
                    OP_WBYTE: begin
                        if (last_bit) begin
                            state <= T_IDLE;
                            done  <= 1'b1;
                        end else begin
                            tx_q    <= tx_q >> 1;
                            bit_cnt <= bit_cnt + 1'b1;
                            go_q    <= 1'b1;
                        end
                    end
                    OP_RBYTE: begin
                        if (last_bit) begin
                            rd_data <= rx_next;
                            state   <= T_IDLE;
                            done    <= 1'b1;
                        end else begin
                            rx_q    <= rx_next;
                            bit_cnt <= bit_cnt + 1'b1;
                            go_q    <= 1'b1;
                        end
                    end
                    default: begin
                        state <= T_IDLE;
                        done  <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign busy = (state == T_RUN);
endmodule

// File: rtl/owire_master_chk.sv
// Protocol checker for the bus master top, attached by bind.
module owire_master_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rd_data,
    input logic              presence,
    input logic              line_drive
);
    // R8
    accept_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op <= 3'd4) |=> busy);

    // R8
    reject_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op > 3'd4) |=> !busy);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rd_data));

    // R10
    pres_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(presence));

    // R11
    drive_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_drive);
endmodule

bind owire_master owire_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .busy       (busy),
    .done       (done),
    .rd_data    (rd_data),
    .presence   (presence),
    .line_drive (line_drive)
);

// File: tb/owire_master_tb.sv
// Bench: the prescaler is shortened so one microsecond is 5 clock cycles.
module owire_master_tb;
    localparam int CLK_HZ_TB = 5_000_000;
    localparam int CPU       = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [7:0] cmd_wdata = '0;
    logic       speed_od = 1'b0;
    logic       line_in;
    logic       busy, done, presence, line_drive;
    logic [7:0] rd_data;
    logic       slave_pull = 1'b0;

    always #10 clk = ~clk;

    assign line_in = ~(line_drive | slave_pull);

    owire_master #(.CLK_HZ(CLK_HZ_TB), .DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .speed_od(speed_od), .line_in(line_in),
        .busy(busy), .done(done), .rd_data(rd_data), .presence(presence),
        .line_drive(line_drive)
    );

    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Low-pulse width monitor and done counter
    int pw[16];
    int npw = 0;
    int cur = 0;
    int done_cnt = 0;
    always @(negedge clk) begin
        if (line_drive) cur++;
        else if (cur > 0) begin
            if (npw < 16) pw[npw] = cur;
            npw++;
            cur = 0;
        end
        if (done) done_cnt++;
    end

    // Device model: mode 1 answers resets with presence, mode 2 returns rpat bits
    int         smode = 0;
    logic [7:0] rpat = '0;
    int         ridx = 0;
    int         pd_dly = 75, pd_len = 500, rd_hold = 150;
    always begin
        @(posedge line_drive);
        @(negedge clk);
        if (smode == 1) begin
            @(negedge line_drive);
            repeat (pd_dly) @(negedge clk);
            slave_pull = 1'b1;
            repeat (pd_len) @(negedge clk);
            slave_pull = 1'b0;
        end else if (smode == 2) begin
            if (!rpat[ridx[2:0]]) begin
                slave_pull = 1'b1;
                repeat (rd_hold) @(negedge clk);
                slave_pull = 1'b0;
            end
            ridx++;
        end
    end

    task automatic set_slave(input int mode, input logic od, input logic [7:0] pat);
        smode   = mode;
        rpat    = pat;
        ridx    = 0;
        pd_dly  = od ? 10 : 75;
        pd_len  = od ? 60 : 500;
        rd_hold = od ? 15 : 150;
    endtask

    task automatic run_op(input logic [2:0] op, input logic od, input logic [7:0] wd,
                          output int bcyc);
        @(negedge clk);
        npw = 0;
        cmd_op = op; speed_od = od; cmd_wdata = wd; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        bcyc = 1;
        while (!done && bcyc < 30000) begin
            @(negedge clk);
            bcyc++;
        end
    endtask

    // Vector table: op, speed, device mode, write data, read pattern, expected value, first low width
    typedef struct packed {
        logic [2:0]  op;
        logic        od;
        logic [1:0]  sm;
        logic [7:0]  wd;
        logic [7:0]  pat;
        logic [7:0]  expv;
        logic [15:0] low1;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 2'd1, 8'h00, 8'h00, 8'h01, 16'd2400},
        '{3'd0, 1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 16'd2400},
        '{3'd0, 1'b1, 2'd1, 8'h00, 8'h00, 8'h01, 16'd350},
        '{3'd1, 1'b0, 2'd0, 8'h01, 8'h00, 8'h00, 16'd30},
        '{3'd1, 1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 16'd300},
        '{3'd1, 1'b1, 2'd0, 8'h01, 8'h00, 8'h00, 16'd5},
        '{3'd1, 1'b1, 2'd0, 8'h00, 8'h00, 8'h00, 16'd35},
        '{3'd2, 1'b0, 2'd2, 8'h00, 8'hFE, 8'h00, 16'd30},
        '{3'd2, 1'b0, 2'd2, 8'h00, 8'h01, 8'h01, 16'd30},
        '{3'd2, 1'b1, 2'd2, 8'h00, 8'hFE, 8'h00, 16'd5},
        '{3'd3, 1'b0, 2'd0, 8'hA5, 8'h00, 8'hA5, 16'd30},
        '{3'd3, 1'b1, 2'd0, 8'h3C, 8'h00, 8'h3C, 16'd35},
        '{3'd4, 1'b0, 2'd2, 8'h00, 8'h96, 8'h96, 16'd30},
        '{3'd4, 1'b1, 2'd2, 8'h00, 8'h4B, 8'h4B, 16'd5}
    };

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int bc;
        int dc0;
        logic [7:0] dec;
        bit wok;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(busy == 0 && done == 0 && line_drive == 0, "R1 idle outputs",
              {busy, done, line_drive}, 0);
        check(rd_data == 0 && presence == 0, "R1 result outputs", {rd_data, presence}, 0);

        // Table walk: R2..R7 across both speeds
        for (int v = 0; v < NV; v++) begin
            set_slave(int'(VECS[v].sm), VECS[v].od, VECS[v].pat);
            dc0 = done_cnt;
            run_op(VECS[v].op, VECS[v].od, VECS[v].wd, bc);
            check(done == 1, {op_tag(VECS[v].op), " completion"}, done, 1);
            check(pw[0] == int'(VECS[v].low1), {op_tag(VECS[v].op), " R7 low width"},
                  pw[0], int'(VECS[v].low1));
            case (VECS[v].op)
                3'd0: check(presence == VECS[v].expv[0], "R2 presence",
                            presence, VECS[v].expv[0]);
                3'd2, 3'd4: check(rd_data == VECS[v].expv, {op_tag(VECS[v].op), " rd_data"},
                                  rd_data, VECS[v].expv);
                3'd3: begin
                    dec = '0; wok = (npw == 8);
                    for (int b = 0; b < 8; b++) begin
                        if (pw[b] == (VECS[v].od ? 5 : 30)) dec[b] = 1'b1;
                        else if (pw[b] != (VECS[v].od ? 35 : 300)) wok = 1'b0;
                    end
                    check(wok && dec == VECS[v].expv, "R5 byte order", dec, VECS[v].expv);
                end
                default: check(npw == 1, "R3 single slot", npw, 1);
            endcase
            @(negedge clk);
            check(done == 0 && done_cnt - dc0 == 1, "R9 done pulse", done_cnt - dc0, 1);
        end
        set_slave(0, 1'b0, 8'h00);

        // R10: reads and writes kept presence from the last reset
        check(presence == 1, "R10 presence held", presence, 1);
        run_op(3'd3, 1'b0, 8'h00, bc);
        check(rd_data == 8'h4B, "R10 write keeps rd_data", rd_data, 8'h4B);
        run_op(3'd0, 1'b0, 8'h00, bc);
        check(presence == 0 && rd_data == 8'h4B, "R10 reset keeps rd_data", rd_data, 8'h4B);

        // R3: slot duration covers low plus recovery (6+64 us)
        run_op(3'd1, 1'b0, 8'h01, bc);
        check(bc >= 70 * CPU && bc <= 70 * CPU + 12, "R3 slot length", bc, 70 * CPU);

        // R7: speed toggled mid-slot has no effect on the running command
        @(negedge clk);
        npw = 0;
        cmd_op = 3'd1; speed_od = 1'b0; cmd_wdata = 8'h00; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (10) @(negedge clk);
        speed_od = 1'b1;
        bc = 0;
        while (!done && bc < 30000) begin @(negedge clk); bc++; end
        check(pw[0] == 300, "R7 mid-op speed change", pw[0], 300);
        run_op(3'd1, 1'b1, 8'h00, bc);
        check(pw[0] == 35, "R7 overdrive after change", pw[0], 35);
        run_op(3'd1, 1'b0, 8'h00, bc);
        check(pw[0] == 300, "R7 back to standard", pw[0], 300);

        // R8: command while busy is ignored
        @(negedge clk);
        npw = 0;
        cmd_op = 3'd1; speed_od = 1'b0; cmd_wdata = 8'h01; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (20) @(negedge clk);
        cmd_op = 3'd3; cmd_wdata = 8'h00; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        bc = 0;
        while (!done && bc < 30000) begin @(negedge clk); bc++; end
        repeat (100) @(negedge clk);
        check(busy == 0 && npw == 1, "R8 busy command ignored", npw, 1);

        // R8: illegal op code ignored
        dc0 = done_cnt;
        npw = 0;
        cmd_op = 3'd6; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (20) @(negedge clk);
        check(busy == 0 && npw == 0 && done_cnt == dc0, "R8 illegal op ignored", npw, 0);

        // R11: released line while idle
        check(line_drive == 0, "R11 idle release", line_drive, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule